// File: doc/BRIEF.md
# Segmented Virtual Address Relocation Unit

This block turns a 16-bit virtual address into an 18-bit physical address for a minicomputer-style memory manager. It keeps one base register and one page descriptor for each of eight pages. It keeps such a set of eight for each processor mode (kernel, supervisor, user) and for each reference space (instruction or data), which makes 48 pairs in all. A request names the page through the top three address bits. It chooses the mode either from the current-mode input or, for move-to/from-previous-space accesses, from the previous-mode input. It also carries the space and a write flag.

The base counts 64-byte blocks. The physical address is the base times 64 plus the 13-bit offset within the page. The descriptor sets how far the page reaches, which way it grows, and what access it grants. A request outside those limits raises an abort flag next to the translated address. The processor decides what to do with a flagged reference. The pairs are loaded and read back through a simple register port.

Top module: `reloc_unit`

## Requirements
- R1: The pair used by a request is chosen by its mode, by `req_dspace` (0 = instruction space, 1 = data space) and by virtual address bits 15-13. Those bits are the page number. Bits 12-0 are the offset within the page.
- R2: One cycle after a cycle with `req_valid` high, `rsp_valid` is high and `rsp_paddr` equals (base × 64 + offset) modulo 2^18. `rsp_valid` is low one cycle after a cycle with `req_valid` low.
- R3: With `req_prev` high, the mode comes from `prev_mode`. With `req_prev` low, it comes from `cur_mode`.
- R4: Mode encoding: 00 is kernel, 01 is supervisor, 11 is user. The value 10 is illegal, and any request made in it aborts.
- R5: Descriptor bits 2-1 set the access. 00 and 10 mean not resident, and every access aborts. 01 means read-only, and writes abort. 11 means read/write.
- R6: Descriptor bits 14-8 hold a length L, and bit 3 = 0 marks an upward page. The block number B is virtual address bits 12-6. On an upward page the access aborts when B > L. The value octal 077406 therefore maps the whole 8K page read/write.
- R7: Bit 3 = 1 marks a downward page. On a downward page the access aborts when B < L.
- R8: `cfg_sel` addresses a pair. Bits 5-4 give the mode slot (0 kernel, 1 supervisor, 2 user), bit 3 gives the space (1 = data) and bits 2-0 give the page. `cfg_desc` picks the descriptor (1) or the base (0). A write with `cfg_we` high takes effect at the clock edge. `cfg_rdata` shows the addressed register in the same cycle. A base reads back as its low 12 bits, zero-extended. A descriptor reads back bits 14-8, 3 and 2-1 only, with all other bits zero.
- R9: A write with `cfg_sel` bits 5-4 = 11 changes nothing, and a read there returns zero.
- R10: Reset clears every pair, so every request aborts. It also clears `rsp_valid` and `rsp_abort`.
- R11: In a cycle after one with no request, `rsp_abort` is low and `rsp_paddr` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_mode | input | 2 | Current processor mode |
| prev_mode | input | 2 | Previous processor mode |
| req_valid | input | 1 | Translation request this cycle |
| req_vaddr | input | 16 | Virtual address |
| req_prev | input | 1 | Translate through the previous mode |
| req_dspace | input | 1 | 1 = data space, 0 = instruction space |
| req_write | input | 1 | 1 = write access |
| rsp_valid | output | 1 | Result registered from last cycle's request |
| rsp_abort | output | 1 | Access violates the selected descriptor or mode |
| rsp_paddr | output | 18 | Physical address |
| cfg_we | input | 1 | Register write strobe |
| cfg_desc | input | 1 | 1 = descriptor, 0 = base |
| cfg_sel | input | 6 | Pair address |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data of the addressed register |

## Verification
The properties assume that the pair used by a request is not rewritten in the same cycle. Under that assumption, the descriptor read alongside the request is the one that decides the abort. They also assume that every input is a known 0 or 1 once reset has been released. The bench meets both conditions. It loads the whole register set before any translation, and it never raises `cfg_we` while a request is present. It drives every input from a defined value at the falling edge. It then sweeps all four mode codes through both mode inputs, both spaces and all eight pages. In each case it uses offsets placed on, just before and just past the block limit, with both reads and writes.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
    parameter int VA_W      = 16;
    parameter int PA_W      = 18;
    parameter int PAGE_BITS = 3;
    parameter int BLK_SHIFT = 6;
    parameter int DATA_W    = 16;
    parameter int MODE_SLOTS = 3;
    parameter int SPACES    = 2;

    localparam int OFF_W  = VA_W - PAGE_BITS;
    localparam int BASE_W = PA_W - BLK_SHIFT;
    localparam int LEN_W  = OFF_W - BLK_SHIFT;
    localparam int PAGES  = 1 << PAGE_BITS;
    localparam int PAIRS  = MODE_SLOTS * SPACES * PAGES;
    localparam int SEL_W  = 2 + 1 + PAGE_BITS;
    localparam int LEN_LSB = 8;

    localparam logic [1:0] MODE_KERN = 2'b00;
    localparam logic [1:0] MODE_SUPV = 2'b01;
    localparam logic [1:0] MODE_BAD  = 2'b10;
    localparam logic [1:0] MODE_USER = 2'b11;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             down;
        logic [1:0]       acf;
    } desc_t;

    typedef struct packed {
        logic            valid;
        logic            abort;
        logic [PA_W-1:0] paddr;
    } rsp_t;

    function automatic desc_t desc_from_word(input logic [DATA_W-1:0] w);
        desc_t d;
        d.len  = w[LEN_LSB +: LEN_W];
        d.down = w[3];
        d.acf  = w[2:1];
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] desc_to_word(input desc_t d);
        logic [DATA_W-1:0] w;
        w = '0;
        w[LEN_LSB +: LEN_W] = d.len;
        w[3]   = d.down;
        w[2:1] = d.acf;
        return w;
    endfunction
endpackage

// File: rtl/reloc_regfile.sv
module reloc_regfile
    import reloc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_desc,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [SEL_W-1:0]  xl_idx,
    output logic [BASE_W-1:0] xl_base,
    output desc_t             xl_desc
);
    logic [BASE_W-1:0] base_q [PAIRS];
    desc_t             desc_q [PAIRS];

    logic cfg_ok, xl_ok;
    assign cfg_ok = (cfg_sel[SEL_W-1 -: 2] != 2'b11);
    assign xl_ok  = (xl_idx[SEL_W-1 -: 2] != 2'b11);

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g] <= '0;
                desc_q[g] <= '0;
            end else if (cfg_we && cfg_sel == SEL_W'(g)) begin
                if (cfg_desc) desc_q[g] <= desc_from_word(cfg_wdata);
                else          base_q[g] <= cfg_wdata[BASE_W-1:0];
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_ok) begin
            if (cfg_desc) cfg_rdata = desc_to_word(desc_q[cfg_sel]);
            else          cfg_rdata = DATA_W'(base_q[cfg_sel]);
        end
    end

    always_comb begin
        xl_base = '0;
        xl_desc = '0;
        if (xl_ok) begin
            xl_base = base_q[xl_idx];
            xl_desc = desc_q[xl_idx];
        end
    end

    // R8: a base write is held in the addressed pair after the edge
    assert_base_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_desc && cfg_ok) |=>
            base_q[$past(cfg_sel)] == $past(cfg_wdata[BASE_W-1:0]));

    // R9: a write in the unused slot leaves pair 0 untouched
    assert_unused_slot_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_ok) |=> $stable(base_q[0]) && $stable(desc_q[0]));
endmodule

// File: rtl/reloc_check.sv
module reloc_check
    import reloc_pkg::*;
(
    input  desc_t            desc,
    input  logic [LEN_W-1:0] blk,
    input  logic             write,
    input  logic             mode_ok,
    output logic             abort
);
    logic nonres, ro_hit, len_hit;

    always_comb begin
        nonres  = !desc.acf[0];
        ro_hit  = (desc.acf == 2'b01) && write;
        len_hit = desc.down ? (blk < desc.len) : (blk > desc.len);
        abort   = !mode_ok || nonres || ro_hit || len_hit;
    end
endmodule

// File: rtl/reloc_unit.sv
module reloc_unit
    import reloc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cur_mode,
    input  logic [1:0]        prev_mode,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_prev,
    input  logic              req_dspace,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic              rsp_abort,
    output logic [PA_W-1:0]   rsp_paddr,
    input  logic              cfg_we,
    input  logic              cfg_desc,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata
);
    rsp_t              rsp_d, rsp_q;
    logic [1:0]        eff_mode;
    logic [1:0]        slot;
    logic              mode_ok;
    logic [SEL_W-1:0]  pair_idx;
    logic [BASE_W-1:0] sel_base;
    desc_t             sel_desc;
    logic              chk_abort;
    logic [PA_W-1:0]   sum;

    always_comb begin
        eff_mode = req_prev ? prev_mode : cur_mode;
        mode_ok  = (eff_mode != MODE_BAD);
        case (eff_mode)
            MODE_KERN: slot = 2'd0;
            MODE_SUPV: slot = 2'd1;
            default:   slot = 2'd2;
        endcase
        pair_idx = {slot, req_dspace, req_vaddr[VA_W-1 -: PAGE_BITS]};
    end

    reloc_regfile i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_desc  (cfg_desc),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .xl_idx    (pair_idx),
        .xl_base   (sel_base),
        .xl_desc   (sel_desc)
    );

    reloc_check i_check (
        .desc    (sel_desc),
        .blk     (req_vaddr[OFF_W-1:BLK_SHIFT]),
        .write   (req_write),
        .mode_ok (mode_ok),
        .abort   (chk_abort)
    );

    always_comb begin
        sum   = {sel_base, {BLK_SHIFT{1'b0}}} + PA_W'(req_vaddr[OFF_W-1:0]);
        rsp_d = rsp_q;
        rsp_d.valid = req_valid;
        rsp_d.abort = req_valid && chk_abort;
        if (req_valid) rsp_d.paddr = sum;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_abort = rsp_q.abort;
    assign rsp_paddr = rsp_q.paddr;

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_offset_low_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_paddr[BLK_SHIFT-1:0] == $past(req_vaddr[BLK_SHIFT-1:0]));

    assert_bad_mode_aborts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && eff_mode == MODE_BAD) |=> rsp_abort);

    assert_nonresident_aborts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !sel_desc.acf[0]) |=> rsp_abort);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_abort && $stable(rsp_paddr));
endmodule

// File: tb/test_reloc_unit.sv
module test_reloc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cur_mode = 2'b00, prev_mode = 2'b00;
    logic        req_valid = 1'b0, req_prev = 1'b0, req_dspace = 1'b0, req_write = 1'b0;
    logic [15:0] req_vaddr = '0;
    logic        rsp_valid, rsp_abort;
    logic [17:0] rsp_paddr;
    logic        cfg_we = 1'b0, cfg_desc = 1'b0;
    logic [5:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;

    int checks = 0;
    int errors = 0;
    int m_base [48];
    int m_len  [48];
    int m_down [48];
    int m_acf  [48];

    always #4 clk = ~clk;

    reloc_unit i_reloc_unit (
        .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode), .prev_mode(prev_mode),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_prev(req_prev),
        .req_dspace(req_dspace), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_abort(rsp_abort), .rsp_paddr(rsp_paddr),
        .cfg_we(cfg_we), .cfg_desc(cfg_desc), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int sel, input bit dsc, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 6'(sel); cfg_desc = dsc; cfg_wdata = 16'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input string tag, input int sel, input bit dsc, input int exp);
        @(negedge clk);
        cfg_sel = 6'(sel); cfg_desc = dsc;
        #1;
        check(tag, int'(cfg_rdata), exp);
    endtask

    task automatic xlate(input string tag, input int cm, input int pm, input bit up,
                         input bit ds, input int va, input bit wr,
                         input int exp_ab, input int exp_pa, input bit chk_pa);
        @(negedge clk);
        cur_mode = 2'(cm); prev_mode = 2'(pm); req_prev = up; req_dspace = ds;
        req_vaddr = 16'(va); req_write = wr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, int'(rsp_valid), 1);
        check({tag, " abort"}, int'(rsp_abort), exp_ab);
        if (chk_pa) check({tag, " paddr"}, int'(rsp_paddr), exp_pa);
    endtask

    function automatic int slot_of(input int m);
        return (m == 3) ? 2 : m;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 rsp_valid after reset", int'(rsp_valid), 0);
        check("R10 rsp_abort after reset", int'(rsp_abort), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cfg_read("R10 base cleared", 5, 1'b0, 0);
        cfg_read("R10 desc cleared", 40, 1'b1, 0);
        xlate("R10 cleared pair aborts", 0, 0, 1'b0, 1'b0, 16'h1234, 1'b0, 1, 0, 1'b0);

        // R8: load all pairs with junk in the unused bits
        for (int i = 0; i < 48; i++) begin
            m_base[i] = (i * 173 + 29) & 12'hFFF;
            m_len[i]  = (i * 23 + 3) & 127;
            m_down[i] = ((i >> 1) ^ (i >> 4)) & 1;
            m_acf[i]  = i % 4;
            cfg_write(i, 1'b0, m_base[i] | 16'hF000);
            cfg_write(i, 1'b1, (m_len[i] << 8) | (m_down[i] << 3) | (m_acf[i] << 1) | 16'h8071);
        end
        // R9: writes into the unused slot
        for (int s = 48; s < 64; s++) begin
            cfg_write(s, 1'b0, 16'hFFFF);
            cfg_write(s, 1'b1, 16'hFFFF);
        end
        for (int s = 0; s < 64; s++) begin
            if (s < 48) begin
                cfg_read("R8 base readback", s, 1'b0, m_base[s]);
                cfg_read("R8 desc readback", s, 1'b1,
                         (m_len[s] << 8) | (m_down[s] << 3) | (m_acf[s] << 1));
            end else begin
                cfg_read("R9 unused base reads zero", s, 1'b0, 0);
                cfg_read("R9 unused desc reads zero", s, 1'b1, 0);
            end
        end

        // R1 R3 R4 R5 R6 R7 R2: sweep
        for (int m = 0; m < 4; m++)
        for (int up = 0; up < 2; up++)
        for (int ds = 0; ds < 2; ds++)
        for (int pg = 0; pg < 8; pg++)
        for (int k = 0; k < 6; k++)
        for (int wr = 0; wr < 2; wr++) begin
            int i, len, off, blk, ab, pa, other;
            bit bad;
            bad = (m == 2);
            i   = slot_of(m) * 16 + ds * 8 + pg;
            if (bad) i = 0;
            len = m_len[i];
            case (k)
                0: off = 0;
                1: off = 13'h1FFF;
                2: off = len * 64;
                3: off = len * 64 + 63;
                4: off = ((len + 1) * 64) & 13'h1FFF;
                default: off = (len == 0) ? 5 : (len - 1) * 64 + 17;
            endcase
            blk = off >> 6;
            ab = (bad || (m_acf[i] & 1) == 0 || (m_acf[i] == 1 && wr == 1) ||
                  (m_down[i] == 1 ? blk < len : blk > len)) ? 1 : 0;
            pa = ((m_base[i] << 6) + off) & 18'h3FFFF;
            other = (m + 1) % 4;
            if (up == 1)
                xlate("R1 R3 R4 R5 R6 R7 R2 prev-mode", other, m, 1'b1, 1'(ds),
                      (pg << 13) | off, 1'(wr), ab, pa, !bad);
            else
                xlate("R1 R4 R5 R6 R7 R2 cur-mode", m, other, 1'b0, 1'(ds),
                      (pg << 13) | off, 1'(wr), ab, pa, !bad);
        end

        // R11: idle cycle keeps address, no abort
        begin
            int last;
            last = int'(rsp_paddr);
            @(negedge clk);
            check("R11 idle valid", int'(rsp_valid), 0);
            check("R11 idle abort", int'(rsp_abort), 0);
            check("R11 idle paddr held", int'(rsp_paddr), last);
        end

        // R6: full-page descriptor, address wraps at 18 bits
        cfg_write(0, 1'b1, 16'o077406);
        cfg_write(0, 1'b0, 12'hFFF);
        cfg_read("R6 full-page desc readback", 0, 1'b1, 16'o077406);
        xlate("R6 R2 full page write wraps", 0, 3, 1'b0, 1'b0, 16'h1FFF, 1'b1, 0, 18'h01FBF, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule